// File: doc/BRIEF.md
# Paged Register Access Sequencer

This block sits on the host side of a management link. It accepts one request at a time for a register that lives behind a paged window. Each request has a page, an offset, a width of 8, 16, 32, 48 or 64 bits, a direction and, for writes, a value. The block breaks the request into a series of 16-bit transactions on a simple management read/write port. A bridge on the far side of that port owns a page register, a command/status register and four 16-bit data registers.

The sequencer keeps a copy of the page it last programmed, so it programs the page register only when the page changes. For a write, it loads the data registers and then issues the command. For a read, it issues the command, waits for completion and then collects the data registers. Completion is found by polling the command/status register, with a fixed number of idle cycles between polls and a limit on how many polls are made. A request that fails ends with an error flag and returns no data.

Top module: `pgreg_seq`

## Requirements
- R1: After reset, `rq_ready` is 1 and both `mg_req` and `rsp_done` are 0. The page cache starts at 0xFF, a page that is never used, so the first request always programs the page register.
- R2: A request whose page differs from the cached page first writes address 0x10 with `{page, 8'h01}`. When that write succeeds, the cache takes the new page. A request to the cached page makes no access to 0x10.
- R3: If the bridge flags an error on the page write, the request ends with `rsp_err` = 1 and the cache keeps its old value. The next request to the same page therefore writes 0x10 again.
- R4: For a write, the value is sent as 16-bit chunks to 0x18, 0x19 and onward, least significant chunk first, before the command. The width code (0 = 8, 1 = 16, 2 = 32, 3 = 48, 4 = 64; codes 5 to 7 behave as 64) gives 1, 1, 2, 3 or 4 chunks. An 8-bit write sends `{8'h00, wdata[7:0]}`.
- R5: The command word goes to address 0x11 as `{offset, 6'b0, op}`, where op is 2'b01 for a write and 2'b10 for a read.
- R6: After the command, address 0x11 is read until bits [1:0] of the read value are both 0; the other bits are ignored. Between one poll's `mg_ack` and the next poll's `mg_req`, `mg_req` stays low for exactly `POLL_WAIT` cycles.
- R7: If `MAX_POLLS` (5) polls all show a busy bit, the request ends with `rsp_err` = 1 and `rsp_rdata` = 0, and no data register is read.
- R8: After completion, a read fetches the data registers from the highest index used down to 0x18. Each chunk is shifted in below the ones already fetched. The result is masked to the width, so an 8-bit read keeps only bits [7:0] of 0x18.
- R9: A request is taken when `rq_valid` and `rq_ready` are both high. `rsp_done` is a one-cycle pulse that carries `rsp_err` and `rsp_rdata`. `rsp_rdata` is 0 for writes.
- R10: `mg_req` is held, with `mg_we`, `mg_addr` and `mg_wdata` stable, until `mg_ack`. An `mg_err` on any transaction, including a data write or the command, ends the request with `rsp_err` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rq_valid | input | 1 | Request offered |
| rq_ready | output | 1 | Sequencer idle and able to take a request |
| rq_write | input | 1 | 1 = write, 0 = read |
| rq_width | input | 3 | Width code (0 = 8, 1 = 16, 2 = 32, 3 = 48, 4 or above = 64 bits) |
| rq_page | input | 8 | Target page |
| rq_offset | input | 8 | Register offset within the page |
| rq_wdata | input | 64 | Write value, right-aligned |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request failed (valid with rsp_done) |
| rsp_rdata | output | 64 | Read value, right-aligned (valid with rsp_done) |
| mg_req | output | 1 | Management transaction request |
| mg_we | output | 1 | Management transaction is a write |
| mg_addr | output | 5 | Management register address |
| mg_wdata | output | 16 | Management write data |
| mg_ack | input | 1 | Transaction complete |
| mg_err | input | 1 | Transaction failed (valid with mg_ack) |
| mg_rdata | input | 16 | Management read data (valid with mg_ack) |

## Verification
The bench builds the block with `POLL_WAIT` = 3 and the default `MAX_POLLS` of 5. With a wait of 3, the wait counter runs through several states, and the fixed 5-cycle spacing between polls can be measured at the bridge model. A poll limit of 5 lets the bridge model hold the busy bit long enough to reach the timeout path, and also to release it on the last allowed poll.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;

    localparam int CHUNK_W = 16;
    localparam int NCHUNK  = 4;
    localparam int DATA_W  = CHUNK_W * NCHUNK;
    localparam int IDX_W   = $clog2(NCHUNK);
    localparam int PAGE_W  = 8;
    localparam int OFF_W   = 8;
    localparam int MADDR_W = 5;

    // Bridge register addresses; the far side decodes these
    localparam logic [MADDR_W-1:0] ADDR_PAGE  = 5'h10;
    localparam logic [MADDR_W-1:0] ADDR_CMD   = 5'h11;
    localparam logic [MADDR_W-1:0] ADDR_DATA0 = 5'h18;

    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;

    typedef enum logic [2:0] {
        S_IDLE, S_PAGE, S_WDATA, S_CMD, S_POLL, S_WAIT, S_RDATA, S_DONE
    } state_e;

    typedef struct packed {
        logic              wr;
        logic [2:0]        width;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  offset;
        logic [DATA_W-1:0] wdata;
    } req_t;

    // Index of the highest data register a width touches
    function automatic logic [IDX_W-1:0] top_chunk(input logic [2:0] w);
        case (w)
            3'd0, 3'd1: top_chunk = IDX_W'(0);
            3'd2:       top_chunk = IDX_W'(1);
            3'd3:       top_chunk = IDX_W'(2);
            default:    top_chunk = IDX_W'(3);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input logic [2:0] w);
        case (w)
            3'd0:    width_mask = DATA_W'({8{1'b1}});
            3'd1:    width_mask = DATA_W'({16{1'b1}});
            3'd2:    width_mask = DATA_W'({32{1'b1}});
            3'd3:    width_mask = DATA_W'({48{1'b1}});
            default: width_mask = {DATA_W{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/pgreg_wait_timer.sv
module pgreg_wait_timer #(
    parameter int WAIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic zero
);
    generate
        if (WAIT > 0) begin : g_count
            localparam int CW = (WAIT > 1) ? $clog2(WAIT) : 1;
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst)
                    cnt <= '0;
                else if (load)
                    cnt <= CW'(WAIT - 1);
                else if (run && cnt != '0)
                    cnt <= cnt - 1'b1;
            end
            assign zero = (cnt == '0);
        end else begin : g_none
            logic unused_in;
            assign unused_in = load ^ run ^ clk ^ rst;
            assign zero = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/pgreg_read_shifter.sv
module pgreg_read_shifter #(
    parameter int CW = 16,
    parameter int N  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            shift,
    input  logic [CW-1:0]   din,
    output logic [CW*N-1:0] acc
);
    localparam int DW = CW * N;

    always_ff @(posedge clk) begin
        if (rst || clear)
            acc <= '0;
        else if (shift)
            acc <= (acc << CW) | DW'(din);
    end
endmodule

// File: rtl/pgreg_chunk_pick.sv
module pgreg_chunk_pick #(
    parameter int CW = 16,
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [CW*N-1:0] data,
    input  logic [IW-1:0]   idx,
    output logic [CW-1:0]   chunk
);
    logic [CW-1:0] parts [N];

    generate
        for (genvar g = 0; g < N; g++) begin : g_part
            assign parts[g] = data[g*CW +: CW];
        end
    endgenerate

    assign chunk = parts[idx];
endmodule

// File: rtl/pgreg_seq.sv
module pgreg_seq
    import pgreg_pkg::*;
#(
    parameter int          POLL_WAIT  = 4,
    parameter int          MAX_POLLS  = 5,
    parameter logic [7:0]  RESET_PAGE = 8'hFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rq_valid,
    output logic        rq_ready,
    input  logic        rq_write,
    input  logic [2:0]  rq_width,
    input  logic [7:0]  rq_page,
    input  logic [7:0]  rq_offset,
    input  logic [63:0] rq_wdata,
    output logic        rsp_done,
    output logic        rsp_err,
    output logic [63:0] rsp_rdata,
    output logic        mg_req,
    output logic        mg_we,
    output logic [4:0]  mg_addr,
    output logic [15:0] mg_wdata,
    input  logic        mg_ack,
    input  logic        mg_err,
    input  logic [15:0] mg_rdata
);
    localparam int PCW = $clog2(MAX_POLLS + 1);

    state_e              state;
    req_t                rq_q;
    logic [PAGE_W-1:0]   page_cache;
    logic [IDX_W-1:0]    idx;
    logic [PCW-1:0]      poll_cnt;
    logic                err_q;

    logic [IDX_W-1:0]    last;
    logic [DATA_W-1:0]   mask;
    logic [CHUNK_W-1:0]  wchunk;
    logic [DATA_W-1:0]   acc;
    logic                accept, busy, last_poll, tmr_load, tmr_zero, shift_en;

    assign last      = top_chunk(rq_q.width);
    assign mask      = width_mask(rq_q.width);
    assign accept    = (state == S_IDLE) && rq_valid;
    assign busy      = (mg_rdata[1:0] != 2'b00);
    assign last_poll = (poll_cnt == PCW'(MAX_POLLS - 1));
    assign tmr_load  = (state == S_POLL) && mg_ack && !mg_err && busy && !last_poll;
    assign shift_en  = (state == S_RDATA) && mg_ack && !mg_err;

    pgreg_chunk_pick #(.CW(CHUNK_W), .N(NCHUNK), .IW(IDX_W)) u_pick (
        .data  (rq_q.wdata & mask),
        .idx   (idx),
        .chunk (wchunk)
    );

    pgreg_read_shifter #(.CW(CHUNK_W), .N(NCHUNK)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .shift (shift_en),
        .din   (mg_rdata),
        .acc   (acc)
    );

    pgreg_wait_timer #(.WAIT(POLL_WAIT)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .run  (state == S_WAIT),
        .zero (tmr_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            rq_q       <= '0;
            page_cache <= RESET_PAGE;
            idx        <= '0;
            poll_cnt   <= '0;
            err_q      <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (rq_valid) begin
                    rq_q     <= '{wr: rq_write, width: rq_width, page: rq_page,
                                  offset: rq_offset, wdata: rq_wdata};
                    err_q    <= 1'b0;
                    poll_cnt <= '0;
                    idx      <= '0;
                    if (rq_page != page_cache) state <= S_PAGE;
                    else if (rq_write)         state <= S_WDATA;
                    else                       state <= S_CMD;
                end
                S_PAGE: if (mg_ack) begin
                    if (mg_err) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end else begin
                        page_cache <= rq_q.page;
                        state      <= rq_q.wr ? S_WDATA : S_CMD;
                    end
                end
                S_WDATA: if (mg_ack) begin
                    if (mg_err) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end else if (idx == last) begin
                        state <= S_CMD;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_CMD: if (mg_ack) begin
                    poll_cnt <= '0;
                    if (mg_err) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end else begin
                        state <= S_POLL;
                    end
                end
                S_POLL: if (mg_ack) begin
                    if (mg_err || (busy && last_poll)) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end else if (!busy) begin
                        idx   <= last;
                        state <= rq_q.wr ? S_DONE : S_RDATA;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                        state    <= (POLL_WAIT > 0) ? S_WAIT : S_POLL;
                    end
                end
                S_WAIT: if (tmr_zero) state <= S_POLL;
                S_RDATA: if (mg_ack) begin
                    if (mg_err) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end else if (idx == '0) begin
                        state <= S_DONE;
                    end else begin
                        idx <= idx - 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mg_req   = 1'b0;
        mg_we    = 1'b0;
        mg_addr  = ADDR_CMD;
        mg_wdata = '0;
        case (state)
            S_PAGE: begin
                mg_req = 1'b1; mg_we = 1'b1; mg_addr = ADDR_PAGE;
                mg_wdata = {rq_q.page, 8'h01};
            end
            S_WDATA: begin
                mg_req = 1'b1; mg_we = 1'b1;
                mg_addr = ADDR_DATA0 + MADDR_W'(idx);
                mg_wdata = wchunk;
            end
            S_CMD: begin
                mg_req = 1'b1; mg_we = 1'b1; mg_addr = ADDR_CMD;
                mg_wdata = {rq_q.offset, 6'b0, rq_q.wr ? OP_WRITE : OP_READ};
            end
            S_POLL:  mg_req = 1'b1;
            S_RDATA: begin
                mg_req = 1'b1;
                mg_addr = ADDR_DATA0 + MADDR_W'(idx);
            end
            default: ;
        endcase
    end

    assign rq_ready  = (state == S_IDLE);
    assign rsp_done  = (state == S_DONE);
    assign rsp_err   = rsp_done && err_q;
    assign rsp_rdata = (rsp_done && !err_q && !rq_q.wr) ? (acc & mask) : '0;

    // R10
    mg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mg_req && !mg_ack) |=> (mg_req && $stable(mg_we) && $stable(mg_addr) && $stable(mg_wdata)));

    // R2
    page_take_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_PAGE && mg_ack && !mg_err) |=> (page_cache == $past(rq_q.page)));

    // R3
    page_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_PAGE && mg_ack && mg_err) |=> $stable(page_cache));

    // R7
    poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_POLL) |-> (poll_cnt < PCW'(MAX_POLLS)));

    // R7
    err_nodata_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_err) |-> (rsp_rdata == '0));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> (!rsp_done && rq_ready));

endmodule

// File: tb/test_pgreg_seq.sv
`timescale 1ns/1ps
module test_pgreg_seq;

    localparam int W   = 3;
    localparam int MXP = 5;

    typedef struct packed {
        logic        wr;
        logic [2:0]  w;
        logic [7:0]  pg;
        logic [7:0]  off;
        logic [2:0]  busy;
        logic [63:0] val;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd1, 8'h02, 8'h10, 3'd0, 64'h0000_0000_0000_1234},
        '{1'b1, 3'd2, 8'h02, 8'h20, 3'd1, 64'h0000_0000_DEAD_BEEF},
        '{1'b0, 3'd4, 8'h02, 8'h30, 3'd2, 64'h1122_3344_5566_7788},
        '{1'b1, 3'd3, 8'h05, 8'h08, 3'd0, 64'h0000_A5A5_5A5A_0F0F},
        '{1'b0, 3'd3, 8'h05, 8'h18, 3'd4, 64'h9999_CAFE_BABE_1357},
        '{1'b0, 3'd0, 8'h05, 8'h00, 3'd0, 64'h0000_0000_0000_ABCD},
        '{1'b1, 3'd0, 8'h07, 8'h44, 3'd0, 64'h0000_0000_0000_77EE},
        '{1'b0, 3'd2, 8'h07, 8'h50, 3'd5, 64'h0000_0000_4321_8765},
        '{1'b1, 3'd4, 8'h07, 8'h60, 3'd0, 64'h0102_0304_0506_0708}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rq_valid = 1'b0;
    logic        rq_ready;
    logic        rq_write = 1'b0;
    logic [2:0]  rq_width = '0;
    logic [7:0]  rq_page = '0;
    logic [7:0]  rq_offset = '0;
    logic [63:0] rq_wdata = '0;
    logic        rsp_done, rsp_err;
    logic [63:0] rsp_rdata;
    logic        mg_req, mg_we;
    logic [4:0]  mg_addr;
    logic [15:0] mg_wdata;
    logic        mg_ack;
    logic        mg_err;
    logic [15:0] mg_rdata;

    always #2.5 clk = ~clk;

    pgreg_seq #(.POLL_WAIT(W), .MAX_POLLS(MXP)) i_pgreg_seq (
        .clk(clk), .rst(rst),
        .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_write(rq_write),
        .rq_width(rq_width), .rq_page(rq_page), .rq_offset(rq_offset),
        .rq_wdata(rq_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .mg_req(mg_req), .mg_we(mg_we),
        .mg_addr(mg_addr), .mg_wdata(mg_wdata), .mg_ack(mg_ack),
        .mg_err(mg_err), .mg_rdata(mg_rdata)
    );

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Bridge model
    logic [15:0] dreg [4];
    int          busy_cfg = 0;
    int          busy_left;
    logic [5:0]  inj_addr = 6'h3F;
    logic        log_clr = 1'b0;
    int          log_n;
    logic [4:0]  log_a [64];
    logic        log_w [64];
    logic [15:0] log_d [64];
    int          poll_t [8];
    int          poll_n;

    always @(posedge clk) begin
        if (rst || log_clr) begin
            log_n  <= 0;
            poll_n <= 0;
        end
        if (rst) begin
            mg_ack    <= 1'b0;
            mg_err    <= 1'b0;
            mg_rdata  <= '0;
            busy_left <= 0;
        end else if (mg_req && !mg_ack) begin
            mg_ack <= 1'b1;
            mg_err <= mg_we && ({1'b0, mg_addr} == inj_addr);
            if (log_n < 64) begin
                log_a[log_n] <= mg_addr;
                log_w[log_n] <= mg_we;
                log_d[log_n] <= mg_wdata;
            end
            log_n <= log_n + 1;
            if (mg_we) begin
                if (mg_addr == 5'h11) busy_left <= busy_cfg;
            end else if (mg_addr == 5'h11) begin
                mg_rdata <= {8'h5A, 6'h00, (busy_left > 0) ? 2'b10 : 2'b00};
                if (busy_left > 0) busy_left <= busy_left - 1;
                if (poll_n < 8) poll_t[poll_n] <= cyc;
                poll_n <= poll_n + 1;
            end else if (mg_addr >= 5'h18) begin
                mg_rdata <= dreg[mg_addr[1:0]];
            end else begin
                mg_rdata <= '0;
            end
        end else begin
            mg_ack <= 1'b0;
            mg_err <= 1'b0;
        end
    end

    task automatic chk(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // Expected transaction list, built from the requirements
    logic [4:0]  ea [64];
    logic        ew [64];
    logic [15:0] ed [64];
    int          en;
    logic        stop;
    logic [7:0]  mcache = 8'hFF;

    task automatic add(input logic we, input logic [4:0] a, input logic [15:0] d);
        if (!stop && en < 64) begin
            ea[en] = a; ew[en] = we; ed[en] = d;
            en++;
            if (we && {1'b0, a} == inj_addr) stop = 1'b1;
        end
    endtask

    function automatic int nchunks(input logic [2:0] w);
        if (w <= 3'd1) return 1;
        if (w == 3'd2) return 2;
        if (w == 3'd3) return 3;
        return 4;
    endfunction

    function automatic logic [63:0] bmask(input logic [2:0] w);
        case (w)
            3'd0: return 64'hFF;
            3'd1: return 64'hFFFF;
            3'd2: return 64'hFFFF_FFFF;
            3'd3: return 64'hFFFF_FFFF_FFFF;
            default: return '1;
        endcase
    endfunction

    task automatic run(input vec_t v, input logic [5:0] inj, input string tag);
        int t;
        int np;
        int nc;
        logic        got_err;
        logic [63:0] got_data;
        logic        exp_err;
        logic [63:0] exp_data;
        logic        seq_ok;
        @(negedge clk);
        inj_addr = inj;
        busy_cfg = int'(v.busy);
        for (int i = 0; i < 4; i++) dreg[i] = v.val[16*i +: 16];
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        // expected sequence
        en = 0; stop = 1'b0;
        nc = nchunks(v.w);
        if (v.pg != mcache) begin
            add(1'b1, 5'h10, {v.pg, 8'h01});
            if (!stop) mcache = v.pg;
        end
        if (v.wr)
            for (int i = 0; i < nc; i++)
                add(1'b1, 5'(5'h18 + i), (v.w == 3'd0) ? {8'h00, v.val[7:0]} : v.val[16*i +: 16]);
        add(1'b1, 5'h11, {v.off, 6'b0, v.wr ? 2'b01 : 2'b10});
        np = (int'(v.busy) + 1 > MXP) ? MXP : int'(v.busy) + 1;
        for (int i = 0; i < np; i++) add(1'b0, 5'h11, 16'h0);
        if (!v.wr && int'(v.busy) < MXP)
            for (int i = nc - 1; i >= 0; i--) add(1'b0, 5'(5'h18 + i), 16'h0);
        exp_err  = stop || (int'(v.busy) >= MXP);
        exp_data = (exp_err || v.wr) ? 64'h0 : (v.val & bmask(v.w));
        // drive request
        rq_write = v.wr; rq_width = v.w; rq_page = v.pg;
        rq_offset = v.off; rq_wdata = v.val; rq_valid = 1'b1;
        @(negedge clk);
        rq_valid = 1'b0;
        t = 0;
        while (!rsp_done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        got_err  = rsp_err;
        got_data = rsp_rdata;
        chk(rsp_done === 1'b1, {tag, " R9 done pulse"}, 64'(rsp_done), 64'h1);
        chk(got_err === exp_err, {tag, " R7/R10 error flag"}, 64'(got_err), 64'(exp_err));
        chk(got_data === exp_data, {tag, " R8/R9 read data"}, got_data, exp_data);
        @(negedge clk);
        chk(rsp_done === 1'b0, {tag, " R9 single pulse"}, 64'(rsp_done), 64'h0);
        seq_ok = (log_n == en);
        for (int i = 0; i < en; i++)
            if (i < log_n && (log_a[i] !== ea[i] || log_w[i] !== ew[i] ||
                              (ew[i] && log_d[i] !== ed[i]))) begin
                seq_ok = 1'b0;
                $display("  entry %0d: got a=%h w=%b d=%h want a=%h w=%b d=%h",
                         i, log_a[i], log_w[i], log_d[i], ea[i], ew[i], ed[i]);
            end
        chk(seq_ok, {tag, " R2/R4/R5/R6/R8 transaction order"}, 64'(log_n), 64'(en));
        if (poll_n > 1 && poll_n <= 8) begin
            logic gap_ok = 1'b1;
            int   bad = 0;
            for (int i = 1; i < poll_n; i++)
                if (poll_t[i] - poll_t[i-1] != 2 + W) begin
                    gap_ok = 1'b0;
                    bad = poll_t[i] - poll_t[i-1];
                end
            chk(gap_ok, {tag, " R6 poll spacing"}, 64'(bad), 64'(2 + W));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rq_ready === 1'b1, "R1 ready after reset", 64'(rq_ready), 64'h1);
        chk(mg_req === 1'b0, "R1 no management request after reset", 64'(mg_req), 64'h0);
        chk(rsp_done === 1'b0, "R1 no done after reset", 64'(rsp_done), 64'h0);

        for (int k = 0; k < NV; k++) begin
            run(VECS[k], 6'h3F, $sformatf("vec%0d", k));
            if (k == 0)
                chk(log_a[0] === 5'h10 && log_d[0] === 16'h0201,
                    "R1 first request programs page", 64'(log_a[0]), 64'h10);
        end

        // R3: failed page write keeps the cache
        run('{1'b0, 3'd1, 8'h09, 8'h04, 3'd0, 64'h0000_0000_0000_4444}, 6'h10, "r3_fail");
        run('{1'b0, 3'd1, 8'h09, 8'h04, 3'd0, 64'h0000_0000_0000_5555}, 6'h3F, "r3_retry");
        chk(log_a[0] === 5'h10, "R3 page reprogrammed after failure", 64'(log_a[0]), 64'h10);

        // R10: error on the command write aborts
        run('{1'b1, 3'd1, 8'h09, 8'h0C, 3'd2, 64'h0000_0000_0000_6666}, 6'h11, "r10_cmd_err");
        // R10: error on a data write aborts
        run('{1'b1, 3'd2, 8'h09, 8'h0E, 3'd0, 64'h0000_0000_1111_2222}, 6'h18, "r10_data_err");

        // R4: width codes above 4 behave as 64 bits
        run('{1'b1, 3'd6, 8'h09, 8'h70, 3'd0, 64'hF0E1_D2C3_B4A5_9687}, 6'h3F, "r4_wide_code");
        chk(log_n == 6 && log_a[3] === 5'h1b, "R4 four chunks for code 6", 64'(log_n), 64'd6);

        // R6: busy released on the last allowed poll
        run('{1'b0, 3'd4, 8'h09, 8'h74, 3'd4, 64'h0A0B_0C0D_0E0F_1011}, 6'h3F, "r6_last_poll");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule